// File: doc/BRIEF.md
# Temperature-Indexed Brightness Correction Engine

This block sits between a junction-temperature measurement and a three-bank PWM dimming stage. Each bank has its own 8-bit brightness code and its own table of small signed corrections, one correction for each 5-degree temperature band. When a new temperature reading arrives, the engine finds the band that holds it and reads each bank's correction for that band. It adds the correction to that bank's code and limits the sum to the legal code range. The three corrected codes then drive the PWM generators. This corrects luminosity drift with temperature and derates the LEDs when they run hot, and each color is corrected on its own.

The tables are loaded and read back through a small synchronous register port. A global enable can switch the correction off, and the user codes then pass through unchanged. The outputs are registered and change only in response to a temperature strobe, so the PWM stage sees a stable code between readings.

Top module: `tcomp_engine`

## Requirements
- R1: While `rst` is high at a clock edge, `corr_codes` is cleared to zero after that edge.
- R2: A temperature T selects table index floor((T + 35) / 5), so band 0 covers -35..-31 and band 30 covers 115..119.
- R3: Temperatures below -35 select index 0, and temperatures of 120 or more select index 31.
- R4: A table write stores a 4-bit two's-complement correction. A written value above +7 is stored as +7, and one below -7 is stored as -7, so the code 1000 never appears in a table.
- R5: With correction on, the output for bank b is user code b plus that bank's selected entry, clamped to 0..255.
- R6: `corr_codes` changes only at the clock edge that follows an edge with `temp_vld` high. The user codes and the enable are sampled at the strobe edge, and changes to the inputs at other times have no effect.
- R7: Bank select 0, 1 and 2 address three separate tables. Bank b reads `user_codes[8b+7:8b]` and drives `corr_codes[8b+7:8b]`. A write with bank select 3 changes no table, and a read with bank select 3 returns 0.
- R8: When `comp_en` is low at the strobe edge, each output equals its user code, whatever the tables hold.
- R9: `tbl_rdata` shows the entry at `tbl_bank`/`tbl_addr`, sign-intact, one clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| comp_en | input | 1 | 1 applies table corrections, 0 passes codes through |
| temp_vld | input | 1 | Strobe: a new temperature reading is on `temp_c` |
| temp_c | input | 9 | Signed temperature in whole degrees |
| user_codes | input | 24 | Three 8-bit brightness codes, bank 0 in the low byte |
| corr_codes | output | 24 | Three corrected 8-bit codes, same layout |
| tbl_we | input | 1 | Table write strobe |
| tbl_bank | input | 2 | Table select (0..2) |
| tbl_addr | input | 5 | Band index inside the table |
| tbl_wdata | input | 8 | Signed correction to write, saturated to -7..+7 |
| tbl_rdata | output | 4 | Signed entry read back, registered |

## Verification
A strobe presented at one edge produces corrected codes two edges later. The first edge registers the looked-up entry together with the sampled codes and enable, and the second edge registers the clamped sum. The bench therefore samples one cycle after the strobe edge to confirm that the old value still holds, and one cycle later to check the new one. A readback is due one edge after the address is driven, and the bench samples it just after that edge. The bench sweeps every temperature from -45 to 135 against a fully loaded table set, with user codes that reach both clamp limits.

// File: rtl/tcomp_pkg.sv
package tcomp_pkg;
  // width of one stored correction and its magnitude limit
  localparam int CORR_W   = 4;
  localparam int CORR_MAX = 7;

  typedef logic signed [CORR_W-1:0] corr_t;
endpackage

// File: rtl/tcomp_band_index.sv
// Maps a signed temperature onto a clamped band index.
module tcomp_band_index #(
  parameter int TEMP_W    = 9,
  parameter int T_MIN     = -35,
  parameter int BAND_DEG  = 5,
  parameter int NUM_BANDS = 32,
  parameter int IDX_W     = 5
) (
  input  logic [TEMP_W-1:0] temp_c,
  output logic [IDX_W-1:0]  idx
);
  localparam int EW = TEMP_W + 2;
  localparam logic signed [EW-1:0] T_MIN_S = EW'(T_MIN);
  localparam logic [EW-1:0] BAND_U = EW'(BAND_DEG);
  localparam logic [EW-1:0] LAST_U = EW'(NUM_BANDS - 1);

  logic signed [EW-1:0] off;
  logic [EW-1:0]        quo;

  always_comb begin
    off = $signed({{2{temp_c[TEMP_W-1]}}, temp_c}) - T_MIN_S;
    quo = $unsigned(off) / BAND_U;
    if (off < 0)
      idx = '0;
    else if (quo > LAST_U)
      idx = IDX_W'(NUM_BANDS - 1);
    else
      idx = quo[IDX_W-1:0];
  end
endmodule

// File: rtl/tcomp_table.sv
// One bank's correction table: one write port, a lookup read and a host read.
module tcomp_table #(
  parameter int NUM_BANDS = 32,
  parameter int IDX_W     = 5,
  parameter int CORR_W    = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [CORR_W-1:0] wdata,
  input  logic [IDX_W-1:0]  lk_addr,
  output logic [CORR_W-1:0] lk_data,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [CORR_W-1:0] rd_data
);
  logic [CORR_W-1:0] mem [NUM_BANDS];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
    lk_data <= mem[lk_addr];
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/tcomp_apply.sv
// Adds a signed correction to an unsigned code, clamping to the code range.
module tcomp_apply #(
  parameter int CODE_W = 8,
  parameter int CORR_W = 4
) (
  input  logic              en,
  input  logic [CODE_W-1:0] code,
  input  logic [CORR_W-1:0] corr,
  output logic [CODE_W-1:0] res
);
  localparam int SW = CODE_W + 2;
  logic signed [SW-1:0] sum;

  always_comb begin
    sum = $signed({2'b00, code}) + $signed({{(SW-CORR_W){corr[CORR_W-1]}}, corr});
    if (!en)
      res = code;
    else if (sum < 0)
      res = '0;
    else if (sum[CODE_W])
      res = '1;
    else
      res = sum[CODE_W-1:0];
  end
endmodule

// File: rtl/tcomp_engine.sv
module tcomp_engine
  import tcomp_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int CODE_W    = 8,
  parameter int TEMP_W    = 9,
  parameter int T_MIN     = -35,
  parameter int BAND_DEG  = 5,
  parameter int NUM_BANDS = 32,
  parameter int WDATA_W   = 8,
  localparam int IDX_W    = $clog2(NUM_BANDS),
  localparam int BSEL_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS + 1) : 1,
  localparam int BUS_W    = NUM_BANKS * CODE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               comp_en,
  input  logic               temp_vld,
  input  logic [TEMP_W-1:0]  temp_c,
  input  logic [BUS_W-1:0]   user_codes,
  output logic [BUS_W-1:0]   corr_codes,
  input  logic               tbl_we,
  input  logic [BSEL_W-1:0]  tbl_bank,
  input  logic [IDX_W-1:0]   tbl_addr,
  input  logic [WDATA_W-1:0] tbl_wdata,
  output logic [CORR_W-1:0]  tbl_rdata
);
  localparam logic signed [WDATA_W-1:0] W_HI = WDATA_W'(CORR_MAX);
  localparam logic signed [WDATA_W-1:0] W_LO = WDATA_W'(-CORR_MAX);

  // band selection
  logic [IDX_W-1:0] band_idx;

  tcomp_band_index #(
    .TEMP_W(TEMP_W), .T_MIN(T_MIN), .BAND_DEG(BAND_DEG),
    .NUM_BANDS(NUM_BANDS), .IDX_W(IDX_W)
  ) band_i (
    .temp_c (temp_c),
    .idx    (band_idx)
  );

  // write-side saturation
  corr_t wsat;
  always_comb begin
    if ($signed(tbl_wdata) > W_HI)
      wsat = CORR_W'(CORR_MAX);
    else if ($signed(tbl_wdata) < W_LO)
      wsat = CORR_W'(-CORR_MAX);
    else
      wsat = tbl_wdata[CORR_W-1:0];
  end

  // strobe pipeline
  logic             vld_q;
  logic             en_q;
  logic [BUS_W-1:0] user_q;

  always_ff @(posedge clk) begin
    if (rst)
      vld_q <= 1'b0;
    else
      vld_q <= temp_vld;
    if (temp_vld) begin
      user_q <= user_codes;
      en_q   <= comp_en;
    end
  end

  logic [CORR_W-1:0] lk_q [NUM_BANKS];
  logic [CORR_W-1:0] rd_q [NUM_BANKS];
  logic [BUS_W-1:0]  res_all;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic we_b;
    assign we_b = tbl_we && (tbl_bank == BSEL_W'(b));

    tcomp_table #(
      .NUM_BANDS(NUM_BANDS), .IDX_W(IDX_W), .CORR_W(CORR_W)
    ) table_i (
      .clk     (clk),
      .we      (we_b),
      .waddr   (tbl_addr),
      .wdata   (wsat),
      .lk_addr (band_idx),
      .lk_data (lk_q[b]),
      .rd_addr (tbl_addr),
      .rd_data (rd_q[b])
    );

    tcomp_apply #(
      .CODE_W(CODE_W), .CORR_W(CORR_W)
    ) apply_i (
      .en   (en_q),
      .code (user_q[b*CODE_W +: CODE_W]),
      .corr (lk_q[b]),
      .res  (res_all[b*CODE_W +: CODE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)
      corr_codes <= '0;
    else if (vld_q)
      corr_codes <= res_all;
  end

  // host readback select
  logic [BSEL_W-1:0] bank_q;
  always_ff @(posedge clk) begin
    bank_q <= tbl_bank;
  end

  always_comb begin
    tbl_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_q == BSEL_W'(b))
        tbl_rdata = rd_q[b];
  end
endmodule

// File: rtl/tcomp_engine_chk.sv
module tcomp_engine_chk #(
  parameter int TEMP_W    = 9,
  parameter int BUS_W     = 24,
  parameter int IDX_W     = 5,
  parameter int CORR_W    = 4,
  parameter int T_MIN     = -35,
  parameter int BAND_DEG  = 5,
  parameter int NUM_BANDS = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              comp_en,
  input logic              temp_vld,
  input logic [TEMP_W-1:0] temp_c,
  input logic [BUS_W-1:0]  user_codes,
  input logic [BUS_W-1:0]  corr_codes,
  input logic [CORR_W-1:0] tbl_rdata,
  input logic [IDX_W-1:0]  band_idx
);
  localparam int T_TOP = T_MIN + BAND_DEG * (NUM_BANDS - 1);

  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (corr_codes == '0));

  p_clamp_low_r3: assert property (@(posedge clk) disable iff (rst)
    ($signed(temp_c) < T_MIN) |-> (band_idx == '0));

  p_clamp_high_r3: assert property (@(posedge clk) disable iff (rst)
    ($signed(temp_c) >= T_TOP) |-> (band_idx == IDX_W'(NUM_BANDS - 1)));

  p_entry_range_r4: assert property (@(posedge clk) disable iff (rst)
    tbl_rdata != {1'b1, {(CORR_W-1){1'b0}}});

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !temp_vld |=> ##1 $stable(corr_codes));

  p_bypass_r8: assert property (@(posedge clk) disable iff (rst)
    (temp_vld && !comp_en) |=> ##1 (corr_codes == $past(user_codes, 2)));
endmodule

bind tcomp_engine tcomp_engine_chk #(
  .TEMP_W(TEMP_W), .BUS_W(BUS_W), .IDX_W(IDX_W), .CORR_W(tcomp_pkg::CORR_W),
  .T_MIN(T_MIN), .BAND_DEG(BAND_DEG), .NUM_BANDS(NUM_BANDS)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .comp_en    (comp_en),
  .temp_vld   (temp_vld),
  .temp_c     (temp_c),
  .user_codes (user_codes),
  .corr_codes (corr_codes),
  .tbl_rdata  (tbl_rdata),
  .band_idx   (band_idx)
);

// File: tb/tcomp_engine_tb_top.sv
module tcomp_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        comp_en;
  logic        temp_vld;
  logic [8:0]  temp_c;
  logic [23:0] user_codes;
  logic [23:0] corr_codes;
  logic        tbl_we;
  logic [1:0]  tbl_bank;
  logic [4:0]  tbl_addr;
  logic [7:0]  tbl_wdata;
  logic [3:0]  tbl_rdata;

  int n_chk = 0;
  int n_bad = 0;
  int model [3][32];
  logic [23:0] last_out;

  always #10 clk = ~clk;

  tcomp_engine dut_i (
    .clk(clk), .rst(rst), .comp_en(comp_en), .temp_vld(temp_vld),
    .temp_c(temp_c), .user_codes(user_codes), .corr_codes(corr_codes),
    .tbl_we(tbl_we), .tbl_bank(tbl_bank), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata)
  );

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0d expected=%0d at %0t", req, got, exp, $time);
    end
  endtask

  function automatic int sat7(input int v);
    return (v > 7) ? 7 : ((v < -7) ? -7 : v);
  endfunction

  function automatic int band_of(input int t);
    int o;
    o = t + 35;
    if (o < 0) return 0;
    o = o / 5;
    return (o > 31) ? 31 : o;
  endfunction

  task automatic wr(input int bank, input int addr, input int val);
    tbl_bank = 2'(bank); tbl_addr = 5'(addr); tbl_wdata = 8'(val); tbl_we = 1'b1;
    @(posedge clk); #1;
    tbl_we = 1'b0;
    if (bank < 3) model[bank][addr] = sat7(val);
  endtask

  task automatic rd(input int bank, input int addr, output int val);
    tbl_bank = 2'(bank); tbl_addr = 5'(addr);
    @(posedge clk); #1;
    val = $signed(tbl_rdata);
  endtask

  // strobe at edge k, old value after k, new value after k+1
  task automatic strobe(input int t, input logic [23:0] codes, input logic en, input string req);
    temp_c = 9'(t); user_codes = codes; comp_en = en; temp_vld = 1'b1;
    @(posedge clk); #1;
    temp_vld = 1'b0;
    user_codes = ~codes; comp_en = ~en;  // must not matter after the strobe edge (R6)
    check("R6", int'(corr_codes), int'(last_out));
    @(posedge clk); #1;
    for (int b = 0; b < 3; b++) begin
      int e;
      e = int'(codes[b*8 +: 8]) + (en ? model[b][band_of(t)] : 0);
      if (e < 0) e = 0;
      if (e > 255) e = 255;
      check(req, int'(corr_codes[b*8 +: 8]), e);
    end
    last_out = corr_codes;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v;
    rst = 1'b1; comp_en = 1'b1; temp_vld = 1'b0; temp_c = '0; user_codes = '0;
    tbl_we = 1'b0; tbl_bank = '0; tbl_addr = '0; tbl_wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(corr_codes), 0);
    rst = 1'b0;
    last_out = '0;

    // load all tables, values -8..8 exercise write saturation
    for (int b = 0; b < 3; b++)
      for (int a = 0; a < 32; a++)
        wr(b, a, ((b * 7 + a * 3) % 17) - 8);
    for (int b = 0; b < 3; b++)
      for (int a = 0; a < 32; a++) begin
        rd(b, a, v);
        check("R9", v, model[b][a]);
      end
    wr(1, 4, 100);  rd(1, 4, v);  check("R4", v, 7);
    wr(2, 9, -100); rd(2, 9, v);  check("R4", v, -7);
    wr(0, 0, -8);   rd(0, 0, v);  check("R4", v, -7);

    // bank select 3 touches nothing and reads zero
    wr(3, 5, 6);
    rd(3, 5, v); check("R7", v, 0);
    for (int b = 0; b < 3; b++) begin
      rd(b, 5, v); check("R7", v, model[b][5]);
    end

    // temperature sweep with clamp limits reached
    for (int t = -45; t <= 135; t++) begin
      logic [23:0] c;
      for (int b = 0; b < 3; b++) begin
        int m;
        m = (t + 100 + b) % 7;
        c[b*8 +: 8] = (m == 0) ? 8'd255 : (m == 1) ? 8'd0 : 8'((t * 37 + b * 91) & 255);
      end
      if (t < -35 || t >= 120) strobe(t, c, 1'b1, "R3");
      else if (t % 2 == 0)     strobe(t, c, 1'b1, "R2");
      else                     strobe(t, c, 1'b1, "R5");
    end

    // bypass
    strobe(50, 24'hFF0001, 1'b0, "R8");
    strobe(-40, 24'h00FF7F, 1'b0, "R8");
    strobe(20, 24'h123456, 1'b1, "R5");

    // no strobe: inputs move, outputs hold
    user_codes = 24'hA5A5A5; temp_c = 9'd3; comp_en = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    check("R6", int'(corr_codes), int'(last_out));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule